// File: doc/BRIEF.md
# Privilege-Aware Interrupt Take Logic

This block decides, once per clock, whether one of a hart's pending interrupts is taken and which privilege level handles it. The hart has three modes: user, supervisor and machine. Each interrupt cause is a candidate when both its pending bit and its per-source enable bit are set. A delegation mask sends a cause either to supervisor mode or to machine mode.

Whether a cause may fire depends on where it is routed compared with the mode the hart is in now. A cause routed to the current mode needs that mode's global enable bit. A cause routed to a more privileged mode is always allowed. A cause routed to a less privileged mode is always held off.

The combinational decision picks one winner by a fixed order and feeds a register stage. The trap logic that follows reads a take strobe, the handling mode and the winning cause number.

Top module: `irq_take_ctrl`

## Requirements
- R1: A cause is a candidate only when `pend_i` and `en_i` are both set for it. Only causes 1, 3, 5, 7, 9 and 11 are ever taken. Every other bit position is ignored.
- R2: A candidate whose `deleg_i` bit is 1 targets supervisor mode (`tgt_mode_o`=1). A candidate whose `deleg_i` bit is 0 targets machine mode (`tgt_mode_o`=3).
- R3: A candidate that targets the current mode is taken only when that mode's global enable is 1. Machine mode uses `mie_i` and supervisor mode uses `sie_i`.
- R4: A candidate that targets a mode less privileged than the current one is never taken, even when `sie_i`=1. For example, a delegated cause is never taken while the hart runs in machine mode.
- R5: A candidate that targets a mode more privileged than the current one is always taken, whatever that mode's global enable says.
- R6: `priv_i` is encoded as user=0, supervisor=1, machine=3. The reserved value 2 behaves as machine mode in every comparison.
- R7: An eligible machine-targeted candidate always wins over an eligible supervisor-targeted one, whatever the cause numbers are.
- R8: Within one target mode, the winner follows the order 11, 9, 3, 1, 7, 5, with the first in this list winning.
- R9: When no candidate is eligible, `take_o` is 0, `tgt_mode_o` is 0 and `cause_o` is 0.
- R10: The outputs are registered. They show the decision for the inputs sampled at the previous rising clock edge. An asynchronous low on `rst_ni` clears all outputs.
- R11: For the supervisor timer interrupt (cause 5), when `deleg_i[5]`=1 it is never taken in machine mode. When `deleg_i[5]`=0 it is taken from user, supervisor or machine mode, the last only when `mie_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege mode |
| mie_i | input | 1 | Machine-mode global interrupt enable |
| sie_i | input | 1 | Supervisor-mode global interrupt enable |
| pend_i | input | NUM_CAUSES | Pending interrupt bits, one per cause |
| en_i | input | NUM_CAUSES | Per-source interrupt enable bits |
| deleg_i | input | NUM_CAUSES | Delegation mask; 1 routes the cause to supervisor mode |
| take_o | output | 1 | Interrupt taken this cycle |
| tgt_mode_o | output | 2 | Privilege mode that handles the taken interrupt |
| cause_o | output | CAUSE_W | Winning cause number |

## Verification
The bench builds the block with `NUM_CAUSES`=16. This leaves bits 12 to 15 and the even low bits available as non-standard positions, so random stimulus regularly checks that those positions are ignored. Random priv values include the reserved encoding 2. Random delegation masks mix machine-targeted and supervisor-targeted candidates in one cycle, so the cross-mode ordering and the relative-privilege enable rule are exercised together with the fixed order within each mode.

// File: rtl/irq_take_pkg.sv
package irq_take_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  localparam int NUM_PRIO = 6;

  // rank 0 is highest priority
  function automatic int prio_cause(input int rank);
    case (rank)
      0:       return 11;
      1:       return 9;
      2:       return 3;
      3:       return 1;
      4:       return 7;
      default: return 5;
    endcase
  endfunction

  function automatic bit is_std_cause(input int c);
    for (int k = 0; k < NUM_PRIO; k++) begin
      if (prio_cause(k) == c) return 1'b1;
    end
    return 1'b0;
  endfunction

  // reserved encoding ranks as machine
  function automatic logic is_m_rank(input logic [1:0] p);
    return p[1];
  endfunction

endpackage

// File: rtl/irq_route.sv
module irq_route
  import irq_take_pkg::*;
#(
  parameter int NUM_CAUSES = 16
) (
  input  logic [1:0]            priv_i,
  input  logic                  mie_i,
  input  logic                  sie_i,
  input  logic [NUM_CAUSES-1:0] pend_i,
  input  logic [NUM_CAUSES-1:0] en_i,
  input  logic [NUM_CAUSES-1:0] deleg_i,
  output logic [NUM_CAUSES-1:0] m_elig_o,
  output logic [NUM_CAUSES-1:0] s_elig_o
);

  logic cur_m;
  logic cur_s;
  logic m_gate;
  logic s_gate;

  assign cur_m  = is_m_rank(priv_i);
  assign cur_s  = (priv_i == PRIV_S);
  // same mode: use own enable; higher target: always on; lower target: off
  assign m_gate = cur_m ? mie_i : 1'b1;
  assign s_gate = cur_m ? 1'b0 : (cur_s ? sie_i : 1'b1);

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_cause
    if (is_std_cause(c)) begin : g_std
      logic cand;
      assign cand        = pend_i[c] & en_i[c];
      assign m_elig_o[c] = cand & ~deleg_i[c] & m_gate;
      assign s_elig_o[c] = cand &  deleg_i[c] & s_gate;
    end else begin : g_nonstd
      assign m_elig_o[c] = 1'b0;
      assign s_elig_o[c] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_take_pkg::*;
#(
  parameter int NUM_CAUSES = 16,
  localparam int CAUSE_W   = $clog2(NUM_CAUSES)
) (
  input  logic [NUM_CAUSES-1:0] elig_i,
  output logic                  hit_o,
  output logic [CAUSE_W-1:0]    cause_o
);

  logic [NUM_PRIO-1:0] req;

  for (genvar k = 0; k < NUM_PRIO; k++) begin : g_req
    assign req[k] = elig_i[prio_cause(k)];
  end

  always_comb begin
    hit_o   = 1'b0;
    cause_o = '0;
    for (int k = NUM_PRIO - 1; k >= 0; k--) begin
      if (req[k]) begin
        hit_o   = 1'b1;
        cause_o = CAUSE_W'(prio_cause(k));
      end
    end
  end

endmodule

// File: rtl/irq_take_ctrl.sv
module irq_take_ctrl
  import irq_take_pkg::*;
#(
  parameter int NUM_CAUSES = 16,
  localparam int CAUSE_W   = $clog2(NUM_CAUSES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            priv_i,
  input  logic                  mie_i,
  input  logic                  sie_i,
  input  logic [NUM_CAUSES-1:0] pend_i,
  input  logic [NUM_CAUSES-1:0] en_i,
  input  logic [NUM_CAUSES-1:0] deleg_i,
  output logic                  take_o,
  output logic [1:0]            tgt_mode_o,
  output logic [CAUSE_W-1:0]    cause_o
);

  logic [NUM_CAUSES-1:0] m_elig;
  logic [NUM_CAUSES-1:0] s_elig;
  logic                  m_hit;
  logic                  s_hit;
  logic [CAUSE_W-1:0]    m_cause;
  logic [CAUSE_W-1:0]    s_cause;
  logic                  take_d;
  logic [1:0]            tgt_d;
  logic [CAUSE_W-1:0]    cause_d;

  irq_route #(.NUM_CAUSES(NUM_CAUSES)) route_i (
    .priv_i   (priv_i),
    .mie_i    (mie_i),
    .sie_i    (sie_i),
    .pend_i   (pend_i),
    .en_i     (en_i),
    .deleg_i  (deleg_i),
    .m_elig_o (m_elig),
    .s_elig_o (s_elig)
  );

  irq_prio_pick #(.NUM_CAUSES(NUM_CAUSES)) pick_m_i (
    .elig_i  (m_elig),
    .hit_o   (m_hit),
    .cause_o (m_cause)
  );

  irq_prio_pick #(.NUM_CAUSES(NUM_CAUSES)) pick_s_i (
    .elig_i  (s_elig),
    .hit_o   (s_hit),
    .cause_o (s_cause)
  );

  // machine-targeted winner takes precedence
  always_comb begin
    take_d  = 1'b0;
    tgt_d   = PRIV_U;
    cause_d = '0;
    if (m_hit) begin
      take_d  = 1'b1;
      tgt_d   = PRIV_M;
      cause_d = m_cause;
    end else if (s_hit) begin
      take_d  = 1'b1;
      tgt_d   = PRIV_S;
      cause_d = s_cause;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o     <= 1'b0;
      tgt_mode_o <= PRIV_U;
      cause_o    <= '0;
    end else begin
      take_o     <= take_d;
      tgt_mode_o <= tgt_d;
      cause_o    <= cause_d;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (cause_o == '0 && tgt_mode_o == PRIV_U)); // R9

  AST_TAKE_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((($past(pend_i) & $past(en_i)) >> cause_o) & NUM_CAUSES'(1)) != '0); // R1

  AST_ROUTE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((((($past(deleg_i) >> cause_o) & NUM_CAUSES'(1)) != '0) ? PRIV_S : PRIV_M)
                == tgt_mode_o)); // R2

  AST_M_SAME_NEEDS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && tgt_mode_o == PRIV_M && $past(priv_i[1])) |-> $past(mie_i)); // R3

  AST_S_SAME_NEEDS_SIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && tgt_mode_o == PRIV_S && $past(priv_i) == PRIV_S) |-> $past(sie_i)); // R3

  AST_NO_LOWER_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(priv_i[1])) |-> tgt_mode_o == PRIV_M); // R4

  AST_HIGHER_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!priv_i[1] && pend_i[11] && en_i[11] && !deleg_i[11])
    |=> (take_o && tgt_mode_o == PRIV_M && cause_o == CAUSE_W'(11))); // R5

endmodule

// File: tb/irq_take_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_take_ctrl_tb_top;

  localparam int NC = 16;
  localparam int CW = $clog2(NC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    priv = '0;
  logic          mie = 1'b0;
  logic          sie = 1'b0;
  logic [NC-1:0] pend = '0;
  logic [NC-1:0] en = '0;
  logic [NC-1:0] deleg = '0;
  logic          take;
  logic [1:0]    tgt;
  logic [CW-1:0] cause;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_take_ctrl #(.NUM_CAUSES(NC)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .priv_i     (priv),
    .mie_i      (mie),
    .sie_i      (sie),
    .pend_i     (pend),
    .en_i       (en),
    .deleg_i    (deleg),
    .take_o     (take),
    .tgt_mode_o (tgt),
    .cause_o    (cause)
  );

  // {take, tgt[1:0], cause[3:0]}
  function automatic logic [6:0] model(input logic [1:0] p, input logic me, input logic se,
                                       input logic [NC-1:0] pe, input logic [NC-1:0] en_v,
                                       input logic [NC-1:0] dl);
    int ord [6] = '{11, 9, 3, 1, 7, 5};
    logic in_m = (p == 2'd2) || (p == 2'd3);
    for (int k = 0; k < 6; k++) begin
      if (pe[ord[k]] && en_v[ord[k]] && !dl[ord[k]] && (in_m ? me : 1'b1))
        return {1'b1, 2'd3, 4'(ord[k])};
    end
    for (int k = 0; k < 6; k++) begin
      if (pe[ord[k]] && en_v[ord[k]] && dl[ord[k]] && !in_m && ((p == 2'd1) ? se : 1'b1))
        return {1'b1, 2'd1, 4'(ord[k])};
    end
    return '0;
  endfunction

  task automatic compare(input logic [6:0] exp, input string tag);
    logic [6:0] act = {take, tgt, 4'(cause)};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual take=%0d tgt=%0d cause=%0d expected take=%0d tgt=%0d cause=%0d",
               tag, act[6], act[5:4], act[3:0], exp[6], exp[5:4], exp[3:0]);
    end
  endtask

  // drive at negedge, one rising edge, sample at next negedge
  task automatic apply(input logic [1:0] p, input logic me, input logic se,
                       input logic [NC-1:0] pe, input logic [NC-1:0] en_v,
                       input logic [NC-1:0] dl, input string tag);
    @(negedge clk);
    priv = p; mie = me; sie = se; pend = pe; en = en_v; deleg = dl;
    @(negedge clk);
    compare(model(p, me, se, pe, en_v, dl), tag);
  endtask

  function automatic logic [NC-1:0] bit_of(input int c);
    return NC'(1) << c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NC-1:0] ones = '1;
    repeat (3) @(negedge clk);
    compare('0, "R10 reset state");
    rst_n = 1'b1;

    apply(2'd0, 1, 1, '0, ones, '0, "R9 nothing pending");
    apply(2'd0, 1, 1, ones, '0, '0, "R1 pending without enable");
    apply(2'd0, 1, 1, 16'hF015, ones, '0, "R1 non-standard positions");
    apply(2'd0, 1, 1, bit_of(9), ones, '0, "R2 undelegated targets machine");
    apply(2'd0, 1, 1, bit_of(9), ones, bit_of(9), "R2 delegated targets supervisor");
    apply(2'd3, 0, 1, bit_of(7), ones, '0, "R3 machine same mode mie off");
    apply(2'd3, 1, 0, bit_of(7), ones, '0, "R3 machine same mode mie on");
    apply(2'd1, 1, 0, bit_of(1), ones, bit_of(1), "R3 supervisor same mode sie off");
    apply(2'd1, 0, 1, bit_of(1), ones, bit_of(1), "R3 supervisor same mode sie on");
    apply(2'd3, 1, 1, bit_of(9), ones, bit_of(9), "R4 supervisor target in machine");
    apply(2'd2, 1, 1, bit_of(9), ones, bit_of(9), "R6 reserved mode blocks supervisor target");
    apply(2'd2, 0, 1, bit_of(3), ones, '0, "R6 reserved mode needs mie");
    apply(2'd1, 0, 0, bit_of(3), ones, '0, "R5 machine target from supervisor");
    apply(2'd0, 0, 0, bit_of(3), ones, bit_of(3), "R5 supervisor target from user");
    apply(2'd3, 1, 1, bit_of(5), ones, bit_of(5), "R11 delegated timer in machine");
    apply(2'd0, 0, 0, bit_of(5), ones, '0, "R11 timer from user");
    apply(2'd1, 0, 0, bit_of(5), ones, '0, "R11 timer from supervisor");
    apply(2'd3, 1, 0, bit_of(5), ones, '0, "R11 timer from machine");
    apply(2'd0, 1, 1, bit_of(11) | bit_of(5), ones, bit_of(11), "R7 machine beats supervisor");
    apply(2'd0, 1, 1, bit_of(11) | bit_of(9) | bit_of(3), ones, '0, "R8 external first");
    apply(2'd0, 1, 1, bit_of(1) | bit_of(7) | bit_of(5), ones, '0, "R8 software before timer");
    apply(2'd0, 1, 1, bit_of(7) | bit_of(5), ones, '0, "R8 timer order");
    apply(2'd0, 1, 1, bit_of(9) | bit_of(3), ones, ones, "R8 order in supervisor");

    // R10: registered, no change before the edge
    apply(2'd0, 1, 1, '0, ones, '0, "R9 clear before latency check");
    @(negedge clk);
    pend = bit_of(11);
    #1 compare('0, "R10 holds before edge");
    @(negedge clk);
    compare(model(2'd0, 1, 1, bit_of(11), ones, '0), "R10 updates after edge");
    #1 rst_n = 1'b0;
    #1 compare('0, "R10 async reset clears");
    @(negedge clk);
    rst_n = 1'b1;

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [NC-1:0] pe = NC'($urandom) & NC'($urandom);
      logic [NC-1:0] ev = NC'($urandom) | NC'($urandom);
      apply(2'($urandom), 1'($urandom), 1'($urandom), pe, ev, NC'($urandom),
            "R8 random mix");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule